// File: doc/BRIEF.md
# Bit-Level Pipelined Ripple Adder

This block adds two 32-bit unsigned operands and a carry-in. It uses a chain of one-bit full-adder cells ordered from the least to the most significant bit. A flip-flop sits on the carry between every pair of neighbouring cells, so the logic between any two registers is a single full adder. Operand bits enter through a staircase of delay registers: bit k waits k cycles, which is exactly how long the carry takes to ripple up to cell k. Each sum bit is then held back by its own delay line, so that all result bits of one operation leave on the same clock.

A new operation can be presented on every clock without stalls. The wide, aligned result arrives a fixed 32 cycles later, in issue order. A valid flag travels alongside the data and marks the cycles that carry a real result. A synchronous reset empties the whole pipeline, including any operations still in flight.

Top module: `pipelined_ripple_adder`

## Requirements
- R1: When `out_valid` is high, `sum` equals (A + B + carry-in) modulo 2^32 for the operation it belongs to, e.g. 0x12345678 + 0x87654321 gives 0x99999999, and 0x7FFFFFFF + 1 gives 0x80000000 with `carry_out` 0.
- R2: When `out_valid` is high, `carry_out` equals bit 32 of the full 33-bit value A + B + carry-in, e.g. 0xFFFFFFFF + 1 gives `sum` 0 and `carry_out` 1.
- R3: `carry_in` adds one unit at the least significant bit, e.g. 0xFFFFFFFF + 0 with carry-in 1 gives `sum` 0 and `carry_out` 1.
- R4: An operation whose inputs are sampled at rising edge n is presented on the outputs right after rising edge n+31, i.e. 32 clock edges from input to output.
- R5: Operations presented on consecutive clocks emerge on consecutive clocks in the order they were issued, and no more results come out than operations went in.
- R6: `out_valid` is high exactly on the cycles that carry the result of a cycle in which `in_valid` was high, and is low on all other cycles, including gaps in the input stream.
- R7: While `rst` is high at a rising edge, that edge clears every pipeline register, so `out_valid`, `sum` and `carry_out` read 0 afterwards; `out_valid` stays low for at least 31 cycles after reset is released.
- R8: A reset asserted while operations are in flight discards them: none of them produce `out_valid` after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks an operation on the operand inputs |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| out_valid | output | 1 | Marks a result on `sum`/`carry_out` |
| sum | output | 32 | Aligned 32-bit sum |
| carry_out | output | 1 | Carry out of bit 31 |

## Verification
Suppose a skew or de-skew delay line has the wrong depth. The affected bit then pairs with the carry or the operands of a neighbouring operation. This shows as a wrong `sum` bit only when consecutive operations differ in that bit, so the stimulus uses back-to-back streams of varied operands. A faulty carry flop shows up within 32 cycles on long ripple patterns such as all-ones plus one. A valid chain that is off by one shows at the ports as a latency other than 32, or as results that appear in gaps or after a mid-stream reset. The bench measures each result's arrival cycle against its issue cycle.

// File: rtl/pra_pkg.sv
package pra_pkg;

    localparam int PRA_WIDTH = 32;

    // Operand bit pair travelling towards one full-adder cell
    typedef struct packed {
        logic x;
        logic y;
    } pra_bitpair_t;

    // Combinational output of one full-adder cell
    typedef struct packed {
        logic s;
        logic c;
    } pra_fa_out_t;

    function automatic pra_fa_out_t pra_full_add(input pra_bitpair_t p, input logic ci);
        pra_fa_out_t r;
        r.s = p.x ^ p.y ^ ci;
        r.c = (p.x & p.y) | (p.y & ci) | (p.x & ci);
        return r;
    endfunction

endpackage

// File: rtl/pra_delay.sv
// Fixed-depth shift register with synchronous clear; DEPTH must be >= 1.
module pra_delay #(
    parameter int W     = 1,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] taps [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
        end else begin
            taps[0] <= d;
            for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
        end
    end

    assign q = taps[DEPTH-1];
endmodule

// File: rtl/pra_stage.sv
// One full-adder cell with its carry flop.
module pra_stage
    import pra_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  pra_bitpair_t opnd,
    input  logic         carry_in,
    output logic         sum_bit,
    output logic         carry_q
);
    pra_fa_out_t fa;

    always_comb fa = pra_full_add(opnd, carry_in);

    assign sum_bit = fa.s;

    always_ff @(posedge clk) begin
        if (rst) carry_q <= 1'b0;
        else     carry_q <= fa.c;
    end
endmodule

// File: rtl/pipelined_ripple_adder.sv
module pipelined_ripple_adder
    import pra_pkg::*;
#(
    parameter int WIDTH = PRA_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             carry_in,
    output logic             out_valid,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    localparam int LATENCY = WIDTH;
    localparam int PAIR_W  = $bits(pra_bitpair_t);

    logic [WIDTH:0]   carry_chain;
    logic [WIDTH-1:0] raw_sum;

    assign carry_chain[0] = carry_in;

    for (genvar k = 0; k < WIDTH; k++) begin : g_bit
        pra_bitpair_t pair_in;
        pra_bitpair_t pair_aligned;

        assign pair_in = '{x: opnd_a[k], y: opnd_b[k]};

        // Operand skew: bit k waits k cycles to meet its carry
        if (k == 0) begin : g_noskew
            assign pair_aligned = pair_in;
        end else begin : g_skew
            pra_delay #(.W(PAIR_W), .DEPTH(k)) u_skew (
                .clk (clk),
                .rst (rst),
                .d   (pair_in),
                .q   (pair_aligned)
            );
        end

        pra_stage u_stage (
            .clk      (clk),
            .rst      (rst),
            .opnd     (pair_aligned),
            .carry_in (carry_chain[k]),
            .sum_bit  (raw_sum[k]),
            .carry_q  (carry_chain[k+1])
        );

        // Result de-skew: bit k waits WIDTH-k cycles so all bits align with the last carry flop
        pra_delay #(.W(1), .DEPTH(WIDTH - k)) u_deskew (
            .clk (clk),
            .rst (rst),
            .d   (raw_sum[k]),
            .q   (sum[k])
        );
    end

    assign carry_out = carry_chain[WIDTH];

    pra_delay #(.W(1), .DEPTH(LATENCY)) u_valid (
        .clk (clk),
        .rst (rst),
        .d   (in_valid),
        .q   (out_valid)
    );
endmodule

// File: rtl/pra_checker.sv
module pra_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic             carry_in,
    input logic             out_valid,
    input logic [WIDTH-1:0] sum,
    input logic             carry_out
);
    localparam int LAT = WIDTH;

    logic [WIDTH:0]   ref_res [LAT];
    logic [LAT-1:0]   ref_vld;
    int unsigned      since_rst;
    int unsigned      in_cnt;
    int unsigned      out_cnt;

    // Behavioural wide-add reference, delayed by the pipeline latency
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LAT; i++) ref_res[i] <= '0;
            ref_vld   <= '0;
            since_rst <= 0;
            in_cnt    <= 0;
            out_cnt   <= 0;
        end else begin
            ref_res[0] <= {1'b0, opnd_a} + {1'b0, opnd_b} + (WIDTH+1)'(carry_in);
            for (int i = 1; i < LAT; i++) ref_res[i] <= ref_res[i-1];
            ref_vld <= {ref_vld[LAT-2:0], in_valid};
            if (since_rst < LAT) since_rst <= since_rst + 1;
            if (in_valid)  in_cnt  <= in_cnt + 1;
            if (out_valid) out_cnt <= out_cnt + 1;
        end
    end

    // R1, R2, R3, R4: aligned result equals the reference 32 cycles on
    a_r1_result_matches: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ({carry_out, sum} == ref_res[LAT-1]));

    // R6: valid flag follows the input flag exactly
    a_r6_valid_aligned: assert property (@(posedge clk) disable iff (rst)
        out_valid == ref_vld[LAT-1]);

    // R7, R8: nothing emerges before the pipeline has refilled after reset
    a_r7_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        (since_rst < LAT) |-> !out_valid);

    // R5: never more results than issued operations
    a_r5_no_extra_result: assert property (@(posedge clk) disable iff (rst)
        out_cnt <= in_cnt);

    // R7: first cycle after reset shows cleared outputs
    a_r7_cleared_outputs: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && sum == '0 && !carry_out));
endmodule

bind pipelined_ripple_adder pra_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/pipelined_ripple_adder_tb.sv
module pipelined_ripple_adder_tb;
    localparam int W   = 32;
    localparam int LAT = 32;
    localparam int NV  = 10;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic        ci;
        logic [31:0] s;
        logic        co;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0},
        '{32'h0000_0001, 32'h0000_0001, 1'b0, 32'h0000_0002, 1'b0},
        '{32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 32'h0000_0000, 1'b1},
        '{32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b1},
        '{32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 32'h8000_0000, 1'b0},
        '{32'h1234_5678, 32'h8765_4321, 1'b0, 32'h9999_9999, 1'b0},
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1'b1},
        '{32'h8000_0000, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1},
        '{32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 32'h0000_0000, 1'b1},
        '{32'hDEAD_BEEF, 32'h0000_0001, 1'b1, 32'hDEAD_BEF1, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [W-1:0]  opnd_a = '0;
    logic [W-1:0]  opnd_b = '0;
    logic          carry_in = 1'b0;
    logic          out_valid;
    logic [W-1:0]  sum;
    logic          carry_out;

    pipelined_ripple_adder #(.WIDTH(W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .carry_in  (carry_in),
        .out_valid (out_valid),
        .sum       (sum),
        .carry_out (carry_out)
    );

    always #2 clk = ~clk;   // 250 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Expected-result queue
    logic [31:0] q_sum [256];
    logic        q_co  [256];
    int          q_cyc [256];
    logic [7:0]  wr_ptr = '0;
    logic [7:0]  rd_ptr = '0;
    logic [31:0] lfsr   = 32'h1ACE_B00C;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] v);
        logic [31:0] t;
        t = v ^ (v << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    // Drive one operation in the next cycle and queue its expected result (R1, R2, R3)
    task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic ci);
        logic [32:0] full;
        @(negedge clk);
        full     = {1'b0, a} + {1'b0, b} + {32'd0, ci};
        opnd_a   = a;
        opnd_b   = b;
        carry_in = ci;
        in_valid = 1'b1;
        q_sum[wr_ptr] = full[31:0];
        q_co[wr_ptr]  = full[32];
        q_cyc[wr_ptr] = cyc;
        wr_ptr = wr_ptr + 1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            opnd_a   = next_rand(opnd_a ^ 32'h5A5A_0001);
            opnd_b   = ~opnd_b;
        end
    endtask

    task automatic issue_rand();
        logic [31:0] a;
        logic [31:0] b;
        lfsr = next_rand(lfsr);
        a    = lfsr;
        lfsr = next_rand(lfsr);
        b    = lfsr;
        issue(a, b, lfsr[7]);
    endtask

    // Output monitor: every result is compared to the queue head (R1, R2, R4, R5, R6)
    always @(negedge clk) begin
        if (rst) begin
            rd_ptr = wr_ptr;
        end else if (out_valid) begin
            if (rd_ptr == wr_ptr) begin
                check(1'b0, "R6", "out_valid without a pending operation", 64'(out_valid), 64'd0);
            end else begin
                check(sum == q_sum[rd_ptr], "R1", "sum", 64'(sum), 64'(q_sum[rd_ptr]));
                check(carry_out == q_co[rd_ptr], "R2", "carry_out", 64'(carry_out), 64'(q_co[rd_ptr]));
                check(cyc - q_cyc[rd_ptr] == LAT, "R4", "latency", 64'(cyc - q_cyc[rd_ptr]), 64'(LAT));
                rd_ptr = rd_ptr + 1;
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=%0d expected=done", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        int seen;
        // R7: reset state
        repeat (4) @(negedge clk);
        check(!out_valid, "R7", "out_valid in reset", 64'(out_valid), 64'd0);
        check(sum == '0, "R7", "sum in reset", 64'(sum), 64'd0);
        check(!carry_out, "R7", "carry_out in reset", 64'(carry_out), 64'd0);
        rst = 1'b0;

        // R7: first result cannot appear before 32 cycles
        issue(32'h0000_0003, 32'h0000_0004, 1'b0);
        seen = 0;
        for (int i = 0; i < LAT - 1; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            if (out_valid) seen++;
        end
        check(seen == 0, "R7", "early out_valid after reset", 64'(seen), 64'd0);
        idle(8);

        // R1, R2, R3, R5: table walked back to back
        for (int v = 0; v < NV; v++) begin
            issue(VECS[v].a, VECS[v].b, VECS[v].ci);
            check({VECS[v].co, VECS[v].s} == {1'b0, VECS[v].a} + {1'b0, VECS[v].b} + {32'd0, VECS[v].ci},
                  "R3", "table entry consistency", 64'(v), 64'(v));
        end
        idle(LAT + 4);
        check(rd_ptr == wr_ptr, "R5", "table results drained", 64'(rd_ptr), 64'(wr_ptr));

        // R6: gapped stream, valid must appear only for issued operations
        for (int i = 0; i < 20; i++) begin
            issue_rand();
            idle(1 + (i % 3));
        end
        idle(LAT + 4);
        check(rd_ptr == wr_ptr, "R6", "gapped results drained", 64'(rd_ptr), 64'(wr_ptr));

        // R5: long back-to-back stream
        for (int i = 0; i < 48; i++) issue_rand();
        idle(LAT + 4);
        check(rd_ptr == wr_ptr, "R5", "back-to-back results drained", 64'(rd_ptr), 64'(wr_ptr));

        // R8: reset while operations are in flight
        for (int i = 0; i < 20; i++) issue_rand();
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(!out_valid && sum == '0 && !carry_out, "R8", "outputs after mid-stream reset",
              {31'd0, out_valid, sum}, 64'd0);
        rst = 1'b0;
        seen = 0;
        for (int i = 0; i < LAT + 8; i++) begin
            @(negedge clk);
            if (out_valid) seen++;
        end
        check(seen == 0, "R8", "flushed operations emerging", 64'(seen), 64'd0);

        // R1, R4: recovery after flush
        issue(32'hFFFF_FFFE, 32'h0000_0001, 1'b1);
        idle(LAT + 4);
        check(rd_ptr == wr_ptr, "R4", "post-flush result drained", 64'(rd_ptr), 64'(wr_ptr));

        done = 1'b1;
        summary();
        $finish;
    end
endmodule